// File: doc/BRIEF.md
# Oversampled Serial Byte Deframer

The deframer takes one serial sample per enabled clock cycle and rebuilds 8-bit bytes that are sent least significant bit first in an asynchronous-serial style frame. A compile-time parameter `HALF_BIT` gives half of one bit period in samples, so a whole bit lasts `2*HALF_BIT` samples. The block waits for a run of ones long enough to count as idle line. The first falling edge after that run starts a frame. The block then counts fixed numbers of samples so that it lands near the middle of each data bit.

Each captured bit is written to a fixed byte position that a one-hot decode of the bit counter selects, so the block has no run-time shifter. When the eighth bit arrives, the finished byte appears on the data output together with a one-cycle valid strobe. In every other cycle the data output reads zero. The block then goes back to looking for idle line.

Top module: `serial_byte_deframer`

## Requirements
- R1: A synchronous reset clears every counter and the assembled byte and returns the block to idle hunting. During reset and in the cycle after it, `dataOut` is 0 and `validOut` is 0. A frame that is interrupted by reset produces no byte.
- R2: A frame may start only after at least `2*HALF_BIT` consecutive enabled samples of 1. A 1-to-0 transition seen before such a run is complete is ignored.
- R3: The enabled sample that shows 0 after the idle run is the transition sample. The following `3*HALF_BIT-1` samples are discarded, and the sample after them becomes bit 0 of the byte, at offset `3*HALF_BIT` from the transition sample.
- R4: Bits 1 to 7 are taken in ascending order, each one after discarding `2*HALF_BIT-1` samples that follow the previous data bit. Bit k therefore sits at offset `3*HALF_BIT + 2*HALF_BIT*k` and is stored in byte bit k.
- R5: `validOut` is high for exactly one cycle: the cycle after the clock edge that consumed bit 7. In that cycle `dataOut` carries the full byte. In all other cycles `dataOut` is 0.
- R6: After bit 7 the block hunts again and needs a fresh run of `2*HALF_BIT` ones before it accepts the next falling edge.
- R7: While `sampleEn` is low, `serialIn` is ignored and no counter or state advances.
- R8: The idle-run counter saturates at `2*HALF_BIT`, so an idle run of any length still arms the block.
- R9: A received byte of 0x00 is reported with `validOut` high, which tells it apart from the idle zero output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| sampleEn | input | 1 | High when `serialIn` holds a sample to consume |
| serialIn | input | 1 | Serial data sample |
| dataOut | output | 8 | Completed byte in the valid cycle, otherwise 0 |
| validOut | output | 1 | One-cycle strobe marking a completed byte |

## Verification
Every non-sampled position inside a frame is driven with the complement of the next bit the block should take. A decoder that skips one sample too many or too few on the first or later bits therefore reads inverted bits instead of getting the right byte by luck. The bench runs three instances with half-bit values 1, 2 and 3. Counter sizing or skip arithmetic that only works for one value gives wrong bytes for the others. Directed cases cover several problems: an idle run one sample short, which a loose arming check would accept and turn into a byte; a re-arm straight after a byte; gaps in the enable, which a design that ignores the enable would sample as garbage; very long idle runs, which would wrap an unsaturated counter and disarm it; a zero byte, which is invisible without the strobe; and reset in the middle of a frame.

// File: rtl/deframer_pkg.sv
package deframer_pkg;

  localparam int BYTE_W = 8;

  typedef enum logic {
    ST_HUNT = 1'b0,
    ST_RECV = 1'b1
  } deframe_state_e;

  // Strobes from control to datapath
  typedef struct packed {
    logic              frameStart; // clear assembly register
    logic              last;       // final bit captured this cycle
    logic [BYTE_W-1:0] bitSel;     // one-hot byte position to load
  } deframe_strb_t;

endpackage

// File: rtl/deframer_ctrl.sv
module deframer_ctrl
  import deframer_pkg::*;
#(
  parameter int HALF_BIT = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          sampleEn,
  input  logic          serialIn,
  output deframe_strb_t strb
);

  localparam int IDLE_MAX   = 2 * HALF_BIT;
  localparam int FIRST_SKIP = 3 * HALF_BIT - 1;
  localparam int NEXT_SKIP  = 2 * HALF_BIT - 1;
  localparam int IDLE_W     = $clog2(IDLE_MAX + 1);
  localparam int SKIP_W     = $clog2(FIRST_SKIP + 1);
  localparam int IDX_W      = $clog2(BYTE_W);

  deframe_state_e    state;
  logic [IDLE_W-1:0] idleCnt;
  logic [SKIP_W-1:0] skipCnt;
  logic [IDX_W-1:0]  bitIdx;

  logic armed;
  logic landing;
  logic lastBit;

  assign armed   = (idleCnt == IDLE_W'(IDLE_MAX));
  assign landing = sampleEn && (state == ST_RECV) && (skipCnt == '0);
  assign lastBit = landing && (bitIdx == IDX_W'(BYTE_W - 1));

  always_comb begin
    strb.frameStart = sampleEn && (state == ST_HUNT) && !serialIn && armed;
    strb.last       = lastBit;
  end

  // One decode line per byte position: fixed-index loading
  for (genvar i = 0; i < BYTE_W; i++) begin : g_sel
    assign strb.bitSel[i] = landing && (bitIdx == IDX_W'(i));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= ST_HUNT;
      idleCnt <= '0;
      skipCnt <= '0;
      bitIdx  <= '0;
    end else if (sampleEn) begin
      unique case (state)
        ST_HUNT: begin
          if (serialIn) begin
            if (!armed) idleCnt <= idleCnt + IDLE_W'(1);
          end else if (armed) begin
            state   <= ST_RECV;
            skipCnt <= SKIP_W'(FIRST_SKIP);
            bitIdx  <= '0;
            idleCnt <= '0;
          end else begin
            idleCnt <= '0;
          end
        end
        ST_RECV: begin
          if (skipCnt != '0) begin
            skipCnt <= skipCnt - SKIP_W'(1);
          end else if (bitIdx == IDX_W'(BYTE_W - 1)) begin
            state   <= ST_HUNT;
            idleCnt <= '0;
          end else begin
            bitIdx  <= bitIdx + IDX_W'(1);
            skipCnt <= SKIP_W'(NEXT_SKIP);
          end
        end
        default: state <= ST_HUNT;
      endcase
    end
  end

  // R8: idle counter never passes its saturation value
  p_idle_sat_r8: assert property (@(posedge clk) disable iff (rst)
    idleCnt <= IDLE_W'(IDLE_MAX));

  // R7: a disabled cycle freezes all control state
  p_hold_r7: assert property (@(posedge clk) disable iff (rst)
    !sampleEn |=> ($stable(state) && $stable(idleCnt) && $stable(skipCnt) && $stable(bitIdx)));

  // R2: a falling edge without a full idle run leaves the block hunting
  p_no_early_start_r2: assert property (@(posedge clk) disable iff (rst)
    (sampleEn && state == ST_HUNT && !serialIn && !armed) |=> (state == ST_HUNT));

  // R3: frame start loads the long first-bit skip
  p_first_skip_r3: assert property (@(posedge clk) disable iff (rst)
    strb.frameStart |=> (state == ST_RECV && skipCnt == SKIP_W'(FIRST_SKIP) && bitIdx == '0));

  // R4: at most one byte position loaded per cycle; bits advance by one
  p_sel_onehot_r4: assert property (@(posedge clk) disable iff (rst)
    $onehot0(strb.bitSel));

  p_ascend_r4: assert property (@(posedge clk) disable iff (rst)
    (landing && !lastBit) |=> (bitIdx == $past(bitIdx) + IDX_W'(1) && skipCnt == SKIP_W'(NEXT_SKIP)));

  // R6: after the final bit the block hunts from an empty idle run
  p_rehunt_r6: assert property (@(posedge clk) disable iff (rst)
    lastBit |=> (state == ST_HUNT && idleCnt == '0));

endmodule

// File: rtl/deframer_dp.sv
module deframer_dp
  import deframer_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              serialIn,
  input  deframe_strb_t     strb,
  output logic [BYTE_W-1:0] dataOut,
  output logic              validOut
);

  logic [BYTE_W-1:0] byteReg;
  logic [BYTE_W-1:0] assembled;

  for (genvar i = 0; i < BYTE_W; i++) begin : g_bit
    always_ff @(posedge clk) begin
      if (rst || strb.frameStart) byteReg[i] <= 1'b0;
      else if (strb.bitSel[i])    byteReg[i] <= serialIn;
    end
    assign assembled[i] = strb.bitSel[i] ? serialIn : byteReg[i];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      dataOut  <= '0;
      validOut <= 1'b0;
    end else if (strb.last) begin
      dataOut  <= assembled;
      validOut <= 1'b1;
    end else begin
      dataOut  <= '0;
      validOut <= 1'b0;
    end
  end

  // R5: output is zero whenever no byte is being presented
  p_zero_idle_r5: assert property (@(posedge clk) disable iff (rst)
    !validOut |-> (dataOut == '0));

  // R5: strobe never lasts two cycles
  p_pulse_r5: assert property (@(posedge clk) disable iff (rst)
    validOut |=> !validOut);

  // R5: strobe follows the final-bit capture one cycle later
  p_after_last_r5: assert property (@(posedge clk) disable iff (rst)
    strb.last |=> validOut);

  // R1: nothing emerges right after reset
  p_reset_quiet_r1: assert property (@(posedge clk)
    rst |=> (!validOut && dataOut == '0));

endmodule

// File: rtl/serial_byte_deframer.sv
module serial_byte_deframer
  import deframer_pkg::*;
#(
  parameter int HALF_BIT = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       sampleEn,
  input  logic       serialIn,
  output logic [7:0] dataOut,
  output logic       validOut
);

  deframe_strb_t strb;

  deframer_ctrl #(.HALF_BIT(HALF_BIT)) u_ctrl (
    .clk      (clk),
    .rst      (rst),
    .sampleEn (sampleEn),
    .serialIn (serialIn),
    .strb     (strb)
  );

  deframer_dp u_dp (
    .clk      (clk),
    .rst      (rst),
    .serialIn (serialIn),
    .strb     (strb),
    .dataOut  (dataOut),
    .validOut (validOut)
  );

endmodule

// File: tb/tb_serial_byte_deframer.sv
`timescale 1ns/1ps
module tb_serial_byte_deframer;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       en  = 1'b0;
  logic [2:0] sIn = 3'b111;
  logic [7:0] dOut [3];
  logic [2:0] vOut;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  for (genvar g = 0; g < 3; g++) begin : g_n
    serial_byte_deframer #(.HALF_BIT(g + 1)) dut (
      .clk      (clk),
      .rst      (rst),
      .sampleEn (en),
      .serialIn (sIn[g]),
      .dataOut  (dOut[g]),
      .validOut (vOut[g])
    );
  end

  // {instance (half-bit = inst+1), idle ones, byte}
  localparam logic [19:0] VEC [10] = '{
    {4'd0, 8'd3,   8'h48},  // R3 R4 R5
    {4'd0, 8'd3,   8'h69},
    {4'd1, 8'd5,   8'h48},
    {4'd1, 8'd5,   8'h69},
    {4'd2, 8'd6,   8'hA5},
    {4'd2, 8'd40,  8'h00},  // R9 R8
    {4'd0, 8'd2,   8'hFF},  // exact minimum idle run
    {4'd1, 8'd4,   8'h01},
    {4'd2, 8'd9,   8'h80},
    {4'd0, 8'd200, 8'h5A}   // R8 long idle
  };

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick(input int inst, input logic b, input logic e);
    sIn[inst] = b;
    en = e;
    @(negedge clk);
  endtask

  // Frame with poisoned skip samples: every non-sampled position holds
  // the complement of the next bit to be taken.
  task automatic sendFrame(input int inst, input int idleOnes, input logic [7:0] byt,
                           input bit expV, input bit gap, input string req);
    int n = inst + 1;
    bit stray = 0;
    bit gotV = 0;
    logic [7:0] gotD = 8'h00;
    for (int i = 0; i < idleOnes; i++) begin
      tick(inst, 1'b1, 1'b1);
      if (vOut[inst]) stray = 1;
    end
    for (int pos = 0; pos <= 17 * n; pos++) begin
      logic val;
      if (pos == 0) val = 1'b0;
      else if (pos >= 3 * n && ((pos - 3 * n) % (2 * n)) == 0) val = byt[(pos - 3 * n) / (2 * n)];
      else begin
        int nb = (pos < 3 * n) ? 0 : ((pos - 3 * n) / (2 * n) + 1);
        val = ~byt[nb];
      end
      tick(inst, val, 1'b1);
      if (pos == 17 * n) begin
        gotV = vOut[inst];
        gotD = dOut[inst];
      end else if (vOut[inst]) stray = 1;
      if (gap && pos < 17 * n) begin
        tick(inst, pos[0], 1'b0);
        if (vOut[inst]) stray = 1;
      end
    end
    sIn[inst] = 1'b1;
    if (expV) check(gotV && gotD == byt, req, {23'd0, gotV, gotD}, {24'd1, byt});
    else      check(!gotV, req, {31'd0, gotV}, 32'd0);
    check(!stray, {req, " no stray strobe"}, {31'd0, stray}, 32'd0);
  endtask

  task automatic doReset();
    rst = 1'b1;
    en = 1'b0;
    sIn = 3'b111;
    @(negedge clk);
    @(negedge clk);
    for (int k = 0; k < 3; k++)
      check(!vOut[k] && dOut[k] == 8'h00, "R1 reset outputs", {23'd0, vOut[k], dOut[k]}, 32'd0);
    rst = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    doReset();

    // Vector table: R3 R4 R5 R8 R9 across half-bit 1..3
    for (int i = 0; i < 10; i++)
      sendFrame(int'(VEC[i][19:16]), int'(VEC[i][15:8]), VEC[i][7:0], 1'b1, 1'b0, "R3/R4/R5 table");

    // R2: idle run one short, falling edge ignored (each half-bit)
    for (int inst = 0; inst < 3; inst++) begin
      doReset();
      sendFrame(inst, 2 * (inst + 1) - 1, 8'h3C, 1'b0, 1'b0, "R2 short idle");
    end

    // R6: right after a byte, a short run must not re-arm
    doReset();
    sendFrame(1, 4, 8'hC3, 1'b1, 1'b0, "R6 first byte");
    sendFrame(1, 3, 8'h3C, 1'b0, 1'b0, "R6 no rearm");
    doReset();
    sendFrame(0, 2, 8'h96, 1'b1, 1'b0, "R6 first byte n1");
    sendFrame(0, 2, 8'h69, 1'b1, 1'b0, "R6 rearm full run");

    // R7: disabled cycles with toggling input are ignored
    doReset();
    sendFrame(0, 3, 8'hB4, 1'b1, 1'b1, "R7 enable gaps n1");
    sendFrame(2, 6, 8'h4B, 1'b1, 1'b1, "R7 enable gaps n3");

    // R1: reset mid-frame abandons it, next frame still decodes
    begin
      bit seen = 0;
      for (int i = 0; i < 4; i++) tick(1, 1'b1, 1'b1);
      tick(1, 1'b0, 1'b1);
      for (int i = 0; i < 10; i++) tick(1, 1'b0, 1'b1);
      rst = 1'b1;
      @(negedge clk);
      rst = 1'b0;
      for (int i = 0; i < 40; i++) begin
        tick(1, 1'b0, 1'b1);
        if (vOut[1]) seen = 1;
      end
      check(!seen, "R1 reset mid-frame", {31'd0, seen}, 32'd0);
      sendFrame(1, 4, 8'h00, 1'b1, 1'b0, "R1 R9 after reset");
    end

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule